// File: doc/BRIEF.md
# Bus-Cycle Single-Step Wait Controller

This block stalls a CPU with an active-low WAIT input and lets it advance one bus cycle at a time. It watches one of several active-low bus strobes, chosen by a select input. When that strobe goes active, the block latches a hold and pulls its WAIT request low. The CPU then stays in the wait state until a release arrives. A release comes either from a debounced step button or from a slow-run tick whose period is programmable.

A free-run mode disables holding altogether. The block's request is ANDed with the target board's own active-low WAIT, so either source can stall the CPU. A status output shows whether a hold is currently latched, which confirms that the chosen cycle or device was actually reached.

Each strobe assertion captures at most once. When stepping on opcode fetches, an instruction with several fetch cycles therefore needs one release per fetch. A change of mode or trigger selection drops any current hold cleanly.

Top module: `bus_step_hold`

## Requirements
- R1: After reset no hold is latched: `hold_active` is 0 and `cpu_wait_n` equals `board_wait_n`.
- R2: In step mode (`run_mode`=1) or slow mode (`run_mode`=2), an active-low assertion of the strobe chosen by `trig_sel` latches a hold within 4 clock cycles. The `trig_sel` index is 0 read, 1 write, 2 opcode fetch, 3 memory request, 4 I/O request, 5 external chip select. Strobe bit k of `strobe_n` is index k.
- R3: Strobes that are not selected, and `trig_sel` values 6 and 7, never latch a hold.
- R4: `cpu_wait_n` is low exactly when `board_wait_n` is low or a hold is latched.
- R5: In step mode, a button press that stays high for at least DEB_CYC consecutive cycles releases the hold. A press shorter than DEB_CYC/2 cycles does not.
- R6: After a release, no new hold is latched while the same strobe stays active. Once the strobe goes inactive and is then asserted again, it latches a new hold.
- R7: In slow mode, a hold lasts exactly (`rate_sel`+1)*PRE_CYC clock cycles and then releases by itself.
- R8: In free mode (`run_mode` 0 or 3), no hold is ever latched.
- R9: In slow mode, the step button has no effect on a latched hold.
- R10: Changing `run_mode` or `trig_sel` while a hold is latched releases it on the next clock edge. A newly selected strobe that is idle can then capture normally.
- R11: `hold_active` is high exactly while a hold is latched, that is, while the block itself drives its WAIT request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| strobe_n | input | 6 | Active-low bus strobes and external chip select, asynchronous |
| trig_sel | input | 3 | Index of the strobe that triggers a hold |
| run_mode | input | 2 | 0/3 free run, 1 single step, 2 slow run |
| step_btn | input | 1 | Raw step button, high when pressed |
| rate_sel | input | 10 | Slow-run period in base ticks, minus one |
| board_wait_n | input | 1 | Active-low WAIT from the target board |
| cpu_wait_n | output | 1 | Merged active-low WAIT to the CPU |
| hold_active | output | 1 | High while a hold is latched |

## Verification
The selected strobe is asserted alone, and then unselected strobes are asserted. This separates a correct index decode from a design that reacts to any strobe. Holding one strobe low across a release, and then toggling it, separates single capture per assertion from a level-sensitive latch. Slow-run holds are measured cycle by cycle at two rate settings, which exposes off-by-one errors in the divider. Short and long button pulses, a press in slow mode, and configuration changes during a hold separate each release source from the others.

// File: rtl/step_pkg.sv
package step_pkg;
  localparam int NSRC = 6;
  localparam int SELW = 3;

  typedef enum logic [1:0] {
    MODE_FREE     = 2'd0,
    MODE_STEP     = 2'd1,
    MODE_SLOW     = 2'd2,
    MODE_FREE_ALT = 2'd3
  } run_mode_t;

  // cycles one slow-run hold lasts
  function automatic int unsigned slow_hold_cycles(input int unsigned rate,
                                                   input int unsigned pre);
    return (rate + 1) * pre;
  endfunction

  function automatic logic mode_holds(input logic [1:0] m);
    return (m == MODE_STEP) || (m == MODE_SLOW);
  endfunction
endpackage

// File: rtl/sync2.sv
module sync2 #(
  parameter int W = 1,
  parameter logic RST_VAL = 1'b0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta <= {W{RST_VAL}};
      q    <= {W{RST_VAL}};
    end else begin
      meta <= d;
      q    <= meta;
    end
  end
endmodule

// File: rtl/btn_debounce.sv
module btn_debounce #(
  parameter int DEB_CYC = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic level,
  output logic press
);
  localparam int CW = $clog2(DEB_CYC + 1);
  localparam logic [CW-1:0] LAST = CW'(DEB_CYC - 1);

  logic          stable;
  logic [CW-1:0] cnt;
  logic          differs;
  logic          settle;

  assign differs = (level != stable);
  assign settle  = differs && (cnt == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stable <= 1'b0;
      cnt    <= '0;
      press  <= 1'b0;
    end else begin
      press <= settle && level;
      if (!differs) begin
        cnt <= '0;
      end else if (settle) begin
        stable <= level;
        cnt    <= '0;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/rate_ticker.sv
module rate_ticker #(
  parameter int PRE_CYC = 125000,
  parameter int RW = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic [RW-1:0] rate,
  output logic          tick
);
  localparam int PW = (PRE_CYC > 1) ? $clog2(PRE_CYC) : 1;
  localparam logic [PW-1:0] PRE_LAST = PW'(PRE_CYC - 1);

  logic [PW-1:0] pre_cnt;
  logic [RW-1:0] base_cnt;
  logic          base_tick;

  assign base_tick = en && (pre_cnt == PRE_LAST);
  assign tick      = base_tick && (base_cnt == rate);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_cnt  <= '0;
      base_cnt <= '0;
    end else if (!en) begin
      pre_cnt  <= '0;
      base_cnt <= '0;
    end else if (base_tick) begin
      pre_cnt  <= '0;
      base_cnt <= tick ? '0 : base_cnt + 1'b1;
    end else begin
      pre_cnt <= pre_cnt + 1'b1;
    end
  end
endmodule

// File: rtl/bus_step_hold.sv
module bus_step_hold
  import step_pkg::*;
#(
  parameter int DEB_CYC = 250000,
  parameter int PRE_CYC = 125000,
  parameter int RW = 10
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] strobe_n,
  input  logic [SELW-1:0] trig_sel,
  input  logic [1:0]      run_mode,
  input  logic            step_btn,
  input  logic [RW-1:0]   rate_sel,
  input  logic            board_wait_n,
  output logic            cpu_wait_n,
  output logic            hold_active
);
  localparam int CFGW = SELW + 2;

  logic [NSRC-1:0] strb_s_n;
  logic [0:0]      btn_s;
  logic [NSRC-1:0] sel_hit;
  logic            sel_active;
  logic            btn_press;
  logic            tick;
  logic            hold;
  logic            armed;
  logic [CFGW-1:0] cfg_q;
  logic            cfg_change;
  logic            capture;
  logic            rel_pulse;

  sync2 #(.W(NSRC), .RST_VAL(1'b1)) u_strb_sync (
    .clk(clk), .rst_n(rst_n), .d(strobe_n), .q(strb_s_n)
  );

  sync2 #(.W(1), .RST_VAL(1'b0)) u_btn_sync (
    .clk(clk), .rst_n(rst_n), .d(step_btn), .q(btn_s)
  );

  btn_debounce #(.DEB_CYC(DEB_CYC)) u_deb (
    .clk(clk), .rst_n(rst_n), .level(btn_s[0]), .press(btn_press)
  );

  rate_ticker #(.PRE_CYC(PRE_CYC), .RW(RW)) u_tick (
    .clk(clk), .rst_n(rst_n),
    .en(hold && (run_mode == MODE_SLOW)),
    .rate(rate_sel), .tick(tick)
  );

  for (genvar i = 0; i < NSRC; i++) begin : g_sel
    assign sel_hit[i] = (trig_sel == SELW'(i)) && !strb_s_n[i];
  end
  assign sel_active = |sel_hit;

  assign cfg_change = ({run_mode, trig_sel} != cfg_q);
  assign capture    = mode_holds(run_mode) && armed && sel_active
                      && !hold && !cfg_change;
  assign rel_pulse  = hold && (((run_mode == MODE_STEP) && btn_press) ||
                               ((run_mode == MODE_SLOW) && tick));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold  <= 1'b0;
      armed <= 1'b0;
      cfg_q <= '0;
    end else begin
      cfg_q <= {run_mode, trig_sel};
      if (cfg_change || rel_pulse) hold <= 1'b0;
      else if (capture)            hold <= 1'b1;
      if (cfg_change || capture)   armed <= 1'b0;
      else if (!sel_active)        armed <= 1'b1;
    end
  end

  assign cpu_wait_n  = board_wait_n & ~hold;
  assign hold_active = hold;
endmodule

// File: rtl/bus_step_hold_chk.sv
module bus_step_hold_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [1:0] run_mode,
  input logic       board_wait_n,
  input logic       cpu_wait_n,
  input logic       hold_active,
  input logic       sel_active,
  input logic       btn_press,
  input logic       rel_pulse,
  input logic       cfg_change
);
  logic is_free;
  assign is_free = (run_mode == 2'd0) || (run_mode == 2'd3);

  AST_BOARD_STALLS: assert property (@(posedge clk) disable iff (!rst_n)
    !board_wait_n |-> !cpu_wait_n); // R4
  AST_HOLD_STALLS: assert property (@(posedge clk) disable iff (!rst_n)
    hold_active |-> !cpu_wait_n); // R11
  AST_CAPTURE_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hold_active) |-> $past(sel_active)); // R2
  AST_RELEASE_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(hold_active) |-> $past(rel_pulse || cfg_change)); // R5
  AST_PRESS_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    btn_press |=> !btn_press); // R5
  AST_FREE_NO_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    is_free |=> !hold_active); // R8
  AST_NO_RECAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(hold_active) && sel_active) |=> !hold_active); // R6
  AST_CFG_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_change && hold_active) |=> !hold_active); // R10
endmodule

bind bus_step_hold bus_step_hold_chk u_chk (
  .clk(clk), .rst_n(rst_n), .run_mode(run_mode),
  .board_wait_n(board_wait_n), .cpu_wait_n(cpu_wait_n),
  .hold_active(hold_active), .sel_active(sel_active),
  .btn_press(btn_press), .rel_pulse(rel_pulse), .cfg_change(cfg_change)
);

// File: tb/tb_bus_step_hold.sv
module tb_bus_step_hold;
  localparam int DEB = 8;
  localparam int PRE = 4;

  logic       clk = 0;
  logic       rst_n = 0;
  logic [5:0] strobe_n = '1;
  logic [2:0] trig_sel = 3'd2;
  logic [1:0] run_mode = 2'd0;
  logic       step_btn = 0;
  logic [9:0] rate_sel = '0;
  logic       board_wait_n = 1;
  logic       cpu_wait_n, hold_active;
  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #4 clk = ~clk;

  bus_step_hold #(.DEB_CYC(DEB), .PRE_CYC(PRE), .RW(10)) dut (
    .clk(clk), .rst_n(rst_n), .strobe_n(strobe_n), .trig_sel(trig_sel),
    .run_mode(run_mode), .step_btn(step_btn), .rate_sel(rate_sel),
    .board_wait_n(board_wait_n), .cpu_wait_n(cpu_wait_n),
    .hold_active(hold_active)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic press(input int len);
    step_btn = 1; cyc(len); step_btn = 0; cyc(DEB + 6);
  endtask

  task automatic t_reset;
    chk(hold_active == 0, "R1 hold after reset", hold_active, 0);
    board_wait_n = 0; cyc(1);
    chk(cpu_wait_n == 0, "R1 wait follows board low", cpu_wait_n, 0);
    board_wait_n = 1; cyc(1);
    chk(cpu_wait_n == 1, "R1 wait follows board high", cpu_wait_n, 1);
  endtask

  task automatic t_step;
    run_mode = 2'd1; trig_sel = 3'd2; cyc(3);
    strobe_n[1] = 0; cyc(6);
    chk(hold_active == 0, "R3 unselected strobe", hold_active, 0);
    strobe_n[1] = 1; strobe_n[2] = 0; cyc(4);
    chk(hold_active == 1, "R2 capture on fetch", hold_active, 1);
    chk(cpu_wait_n == 0, "R4 wait low while held", cpu_wait_n, 0);
    press(DEB / 2 - 1);
    chk(hold_active == 1, "R5 short press ignored", hold_active, 1);
    press(DEB + 4);
    chk(hold_active == 0, "R5 long press releases", hold_active, 0);
    chk(cpu_wait_n == 1, "R11 wait freed", cpu_wait_n, 1);
    cyc(8);
    chk(hold_active == 0, "R6 no recapture on same strobe", hold_active, 0);
    strobe_n[2] = 1; cyc(4); strobe_n[2] = 0; cyc(4);
    chk(hold_active == 1, "R6 new fetch captures", hold_active, 1);
    board_wait_n = 0; cyc(1);
    chk(cpu_wait_n == 0, "R4 both low", cpu_wait_n, 0);
    board_wait_n = 1;
    trig_sel = 3'd0; cyc(2);
    chk(hold_active == 0, "R10 select change releases", hold_active, 0);
    strobe_n[2] = 1; strobe_n[0] = 0; cyc(4);
    chk(hold_active == 1, "R10 new select captures", hold_active, 1);
    strobe_n[0] = 1;
    trig_sel = 3'd6; cyc(2);
    chk(hold_active == 0, "R10 select change releases again", hold_active, 0);
    strobe_n = '0; cyc(6);
    chk(hold_active == 0, "R3 out-of-range select", hold_active, 0);
    strobe_n = '1; trig_sel = 3'd5; cyc(3);
    strobe_n[5] = 0; cyc(4);
    chk(hold_active == 1, "R2 chip select capture", hold_active, 1);
    run_mode = 2'd0; cyc(2);
    chk(hold_active == 0, "R10 mode change releases", hold_active, 0);
    strobe_n[5] = 1;
  endtask

  task automatic slow_measure(input int rate, input int exp, input string tag);
    int n = 0, guard = 0;
    rate_sel = 10'(rate); run_mode = 2'd2; trig_sel = 3'd3; cyc(3);
    strobe_n[3] = 0;
    while (cpu_wait_n && guard < 10) begin cyc(1); guard++; end
    while (!cpu_wait_n && n < 600) begin cyc(1); n++; end
    chk(n == exp, tag, n, exp);
    strobe_n[3] = 1; cyc(3);
  endtask

  task automatic t_slow;
    slow_measure(2, 3 * PRE, "R7 slow period rate 2");
    slow_measure(5, 6 * PRE, "R7 slow period rate 5");
    rate_sel = 10'd100; strobe_n[3] = 0; cyc(4);
    chk(hold_active == 1, "R9 held in slow mode", hold_active, 1);
    press(DEB + 4);
    chk(hold_active == 1, "R9 button ignored in slow", hold_active, 1);
    run_mode = 2'd3; cyc(2);
    chk(hold_active == 0, "R8 free mode drops hold", hold_active, 0);
    strobe_n[3] = 1; cyc(3); strobe_n[3] = 0; cyc(8);
    chk(hold_active == 0, "R8 no hold in free mode", hold_active, 0);
    chk(cpu_wait_n == 1, "R8 wait high in free", cpu_wait_n, 1);
    strobe_n[3] = 1;
  endtask

  initial begin
    cyc(3); rst_n = 1; cyc(2);
    t_reset();
    t_step();
    t_slow();
    done = 1;
  end

  initial begin
    for (int i = 0; i < 20000 && !done; i++) @(posedge clk);
    if (!done) chk(0, "watchdog", 0, 1);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule